// File: doc/BRIEF.md
# DRAM Idle Low-Power Sequencer

This block counts consecutive idle cycles on a memory bus. As the count grows, it asks the memory subsystem to move into deeper and deeper low-power states. There are five states past active, from shallowest to deepest:

- power-down;
- self-refresh;
- self-refresh with the controller clock stopped;
- a self-refresh power-down that is allowed only for LPDDR4 devices;
- standby, in which the controller, PHY-interface, PHY and DRAM clocks are all stopped.

Each state has its own programmable threshold, counted in DFI clock cycles. The DFI clock runs at half the DRAM clock. The three middle thresholds are in units of 1024 cycles. The power-down and standby thresholds are raw cycle counts.

The state request is a one-hot vector, and four clock-stop enables are decoded from it. When a bus request or a busy indication arrives in any low-power state, the block goes back to active. It then holds a wake-pending flag until the exit logic answers with an exit-done pulse. The thresholds and the DRAM-type flag are captured only while the block is active, so a configuration change during a sequence cannot disturb it.

Top module: `dram_lp_seq`

## Requirements
- R1: After reset the state request is active (bit 0), the wake-pending flag and all clock-stop outputs are low, and every captured threshold is zero.
- R2: With a nonzero power-down threshold P, power-down (state bit 1) is requested at the same clock edge that samples the P-th consecutive idle cycle. An idle cycle is one with bus_idle=1 and bus_req=0.
- R3: Self-refresh (bit 2), self-refresh with controller clock stopped (bit 3) and self-refresh power-down (bit 4) are entered at the edge that samples the (T×1024)-th consecutive idle cycle, where T is that state's threshold.
- R4: Standby (bit 5) is entered at the edge that samples the S-th consecutive idle cycle, where S is its threshold with no scaling.
- R5: A threshold of zero disables its state, and the sequence skips it.
- R6: When several thresholds are met at once, the deepest enabled state is requested. While the bus stays idle the state never becomes shallower.
- R7: Self-refresh power-down is reachable only if the DRAM-type input (1 = LPDDR4) was high when the configuration was captured.
- R8: A non-idle cycle clears the idle count, so counting toward every threshold starts again from the next idle cycle.
- R9: A non-idle cycle in any low-power state returns the state to active at that edge and sets the wake-pending flag. The flag stays high until a sampled exit_done pulse clears it. While it is high, no low-power state is entered.
- R10: Thresholds and the DRAM-type flag are captured at every edge where the state is active, and are held unchanged in every other state.
- R11: gate_ctrl_clk is high in states 3, 4 and 5. gate_pi_clk, gate_phy_clk and gate_dram_clk are high only in state 5. All four are low in states 0, 1 and 2.
- R12: state_req is always one-hot. Bit 0 is active, then bits 1 to 5 in the order power-down, self-refresh, self-refresh with controller clock stopped, self-refresh power-down, standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | Bus has no outstanding traffic this cycle |
| bus_req | input | 1 | New bus request this cycle |
| exit_done | input | 1 | Low-power exit has completed |
| dram_is_lp4 | input | 1 | Attached DRAM type is LPDDR4 |
| cfg_pd_thr | input | THR_W | Power-down threshold, in cycles |
| cfg_sr_thr | input | THR_W | Self-refresh threshold, in units of 1024 cycles |
| cfg_srcg_thr | input | THR_W | Self-refresh with controller clock stopped, in units of 1024 cycles |
| cfg_srpd_thr | input | THR_W | Self-refresh power-down threshold, in units of 1024 cycles |
| cfg_stby_thr | input | THR_W | Standby threshold, in cycles |
| state_req | output | 6 | One-hot state request |
| gate_ctrl_clk | output | 1 | Stop the controller clock |
| gate_pi_clk | output | 1 | Stop the PHY-interface clock |
| gate_phy_clk | output | 1 | Stop the PHY clock |
| gate_dram_clk | output | 1 | Stop the DRAM clock |
| wake_pend | output | 1 | Wake issued, exit not yet confirmed |

## Verification
The bench probes the exact edge of each threshold, one cycle before and at the P-th or T×1024-th idle cycle. A design that is off by one, or that scales the wrong thresholds, requests a state a cycle early, a cycle late, or about a thousand cycles off.

Several directed cases target specific mistakes:

- Thresholds that coincide are set up to catch a design that takes the shallowest state instead of the deepest.
- Zero thresholds are set up to catch a design that treats zero as "enter at once".
- A cleared DRAM-type flag is set up to catch a design that wrongly enters the LPDDR4-only state.

Other cases check the wake path:

- A configuration is changed in the middle of a sequence. A design that captures it outside the active state jumps to, or skips, a state.
- Idle cycles are held while wake-pending is high. This catches an early re-entry that the exit handshake has not yet allowed.

Constrained-random episodes mix bursts, wakes and exit pulses to cover the orderings that the directed cases do not reach.

// File: rtl/dram_lp_seq.sv
module dram_lp_seq #(
  parameter int THR_W = 16,
  parameter int SCALE_SH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic             bus_req,
  input  logic             exit_done,
  input  logic             dram_is_lp4,
  input  logic [THR_W-1:0] cfg_pd_thr,
  input  logic [THR_W-1:0] cfg_sr_thr,
  input  logic [THR_W-1:0] cfg_srcg_thr,
  input  logic [THR_W-1:0] cfg_srpd_thr,
  input  logic [THR_W-1:0] cfg_stby_thr,
  output logic [5:0]       state_req,
  output logic             gate_ctrl_clk,
  output logic             gate_pi_clk,
  output logic             gate_phy_clk,
  output logic             gate_dram_clk,
  output logic             wake_pend
);
  localparam int NS    = 6;
  localparam int CNT_W = THR_W + SCALE_SH;
  localparam int IDX_W = $clog2(NS);

  logic [NS-1:0]    st;
  logic [THR_W-1:0] t_pd, t_sr, t_cg, t_sp, t_sb;
  logic             lp4_q;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             pend_q;
  logic [NS-1:1]    hit;
  logic [IDX_W-1:0] tgt, cur;

  wire busy     = ~bus_idle | bus_req;
  wire idle_now = ~busy & ~pend_q;
  wire active   = st[0];

  assign cnt_nxt = idle_now ? ((&cnt) ? cnt : cnt + 1'b1) : '0;

  assign hit[1] = (t_pd != '0) && (cnt_nxt >= CNT_W'(t_pd));
  assign hit[2] = (t_sr != '0) && (cnt_nxt >= {t_sr, {SCALE_SH{1'b0}}});
  assign hit[3] = (t_cg != '0) && (cnt_nxt >= {t_cg, {SCALE_SH{1'b0}}});
  assign hit[4] = lp4_q && (t_sp != '0) && (cnt_nxt >= {t_sp, {SCALE_SH{1'b0}}});
  assign hit[5] = (t_sb != '0) && (cnt_nxt >= CNT_W'(t_sb));

  always_comb begin
    tgt = '0;
    cur = '0;
    for (int i = 1; i < NS; i++) begin
      if (hit[i]) tgt = IDX_W'(i);
      if (st[i])  cur = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= NS'(1);
      cnt    <= '0;
      pend_q <= 1'b0;
      t_pd   <= '0;
      t_sr   <= '0;
      t_cg   <= '0;
      t_sp   <= '0;
      t_sb   <= '0;
      lp4_q  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (active) begin
        t_pd  <= cfg_pd_thr;
        t_sr  <= cfg_sr_thr;
        t_cg  <= cfg_srcg_thr;
        t_sp  <= cfg_srpd_thr;
        t_sb  <= cfg_stby_thr;
        lp4_q <= dram_is_lp4;
      end
      if (!active && busy) begin
        st     <= NS'(1);
        pend_q <= 1'b1;
      end else begin
        if (exit_done) pend_q <= 1'b0;
        if (tgt > cur) st <= NS'(1) << tgt;
      end
    end
  end

  assign state_req     = st;
  assign wake_pend     = pend_q;
  assign gate_ctrl_clk = st[3] | st[4] | st[5];
  assign gate_pi_clk   = st[5];
  assign gate_phy_clk  = st[5];
  assign gate_dram_clk = st[5];

  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot(st));
  a_r6_no_shallower: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (st >= $past(st)));
  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[0] && busy) |=> (st[0] && pend_q));
  a_r9_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> st[0]);
  a_r7_lp4_only: assert property (@(posedge clk) disable iff (!rst_n)
    st[4] |-> lp4_q);
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !st[0] |=> ($stable(t_pd) && $stable(t_sr) && $stable(t_cg) &&
                $stable(t_sp) && $stable(t_sb) && $stable(lp4_q)));
endmodule

// File: tb/tb_dram_lp_seq.sv
module tb_dram_lp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int THR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_idle = 1'b0, bus_req = 1'b0, exit_done = 1'b0, dram_is_lp4 = 1'b0;
  logic [THR_W-1:0] cfg_pd_thr = '0, cfg_sr_thr = '0, cfg_srcg_thr = '0,
                    cfg_srpd_thr = '0, cfg_stby_thr = '0;
  logic [5:0] state_req;
  logic gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk, wake_pend;

  int n_chk = 0, n_bad = 0;
  bit chk_en = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_lp_seq #(.THR_W(THR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .bus_req(bus_req),
    .exit_done(exit_done), .dram_is_lp4(dram_is_lp4),
    .cfg_pd_thr(cfg_pd_thr), .cfg_sr_thr(cfg_sr_thr), .cfg_srcg_thr(cfg_srcg_thr),
    .cfg_srpd_thr(cfg_srpd_thr), .cfg_stby_thr(cfg_stby_thr),
    .state_req(state_req), .gate_ctrl_clk(gate_ctrl_clk), .gate_pi_clk(gate_pi_clk),
    .gate_phy_clk(gate_phy_clk), .gate_dram_clk(gate_dram_clk), .wake_pend(wake_pend));

  // reference model built from the requirements
  int m_st, m_cnt, m_pend, m_lp4;
  int m_pd, m_sr, m_cg, m_sp, m_sb;

  function automatic int deepest(int c, int pd, int sr, int cg, int sp, int sb, int lp4);
    int d = 0;
    if (pd != 0 && c >= pd) d = 1;
    if (sr != 0 && c >= sr * 1024) d = 2;
    if (cg != 0 && c >= cg * 1024) d = 3;
    if (lp4 != 0 && sp != 0 && c >= sp * 1024) d = 4;
    if (sb != 0 && c >= sb) d = 5;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pend = 0; m_lp4 = 0;
      m_pd = 0; m_sr = 0; m_cg = 0; m_sp = 0; m_sb = 0;
    end else begin
      bit busy;
      int cn, tg, old;
      busy = !bus_idle || bus_req;
      cn = (!busy && m_pend == 0) ? m_cnt + 1 : 0;
      tg = deepest(cn, m_pd, m_sr, m_cg, m_sp, m_sb, m_lp4);
      old = m_st;
      if (old == 0) begin
        m_pd = cfg_pd_thr; m_sr = cfg_sr_thr; m_cg = cfg_srcg_thr;
        m_sp = cfg_srpd_thr; m_sb = cfg_stby_thr; m_lp4 = dram_is_lp4;
      end
      if (old != 0 && busy) begin
        m_st = 0; m_pend = 1;
      end else begin
        if (exit_done) m_pend = 0;
        if (tg > old) m_st = tg;
      end
      m_cnt = cn;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      check("R12 state", state_req, 1 << m_st);
      check("R11 gates", {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk},
            {(m_st >= 3), (m_st == 5), (m_st == 5), (m_st == 5)});
      check("R9 wake_pend", wake_pend, m_pend);
    end
  end

  task automatic cyc(bit idl, bit req, bit ex);
    bus_idle = idl; bus_req = req; exit_done = ex;
    @(negedge clk);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0);
  endtask

  task automatic setcfg(int pd, int sr, int cg, int sp, int sb, bit lp4);
    cfg_pd_thr = THR_W'(pd); cfg_sr_thr = THR_W'(sr); cfg_srcg_thr = THR_W'(cg);
    cfg_srpd_thr = THR_W'(sp); cfg_stby_thr = THR_W'(sb); dram_is_lp4 = lp4;
  endtask

  task automatic recover();
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    cyc(0, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1;
    // R1 reset state, R12 encoding
    check("R1 state", state_req, 6'b000001);
    check("R1 gates", {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk, wake_pend}, 0);
    idle_n(2000);
    check("R1 zero thresholds stay active", state_req, 6'b000001);

    // R2 power-down edge, R8 count clear
    setcfg(10, 0, 0, 0, 0, 0); cyc(0, 0, 0);
    idle_n(9); cyc(0, 0, 0); idle_n(9);
    check("R8 count cleared", state_req, 6'b000001);
    check("R8 no wake in active", wake_pend, 0);
    idle_n(1);
    check("R2 pd at 10th idle", state_req, 6'b000010);
    recover();

    // R3 self-refresh at 1024, R9 wake and hold
    setcfg(5, 1, 0, 0, 0, 0); cyc(0, 0, 0);
    idle_n(1023);
    check("R3 before 1024", state_req, 6'b000010);
    idle_n(1);
    check("R3 sr at 1024", state_req, 6'b000100);
    cyc(0, 1, 0);
    check("R9 wake state", state_req, 6'b000001);
    check("R9 wake flag", wake_pend, 1);
    idle_n(20);
    check("R9 no entry while pending", state_req, 6'b000001);
    check("R9 flag held", wake_pend, 1);
    cyc(1, 0, 1);
    check("R9 flag cleared", wake_pend, 0);
    idle_n(5);
    check("R9 counting resumes", state_req, 6'b000010);
    recover();

    // R5 skip zero thresholds, R11 controller gate
    setcfg(0, 0, 1, 0, 0, 0); cyc(0, 0, 0);
    idle_n(1023);
    check("R5 skipped states", state_req, 6'b000001);
    idle_n(1);
    check("R5 srcg reached", state_req, 6'b001000);
    check("R11 ctrl gated only", {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk}, 4'b1000);
    recover();

    // R6 deepest wins, R4 unscaled standby
    setcfg(3, 0, 0, 0, 3, 0); cyc(0, 0, 0);
    idle_n(2);
    check("R6 before tie", state_req, 6'b000001);
    idle_n(1);
    check("R6 deepest on tie", state_req, 6'b100000);
    check("R11 all gated", {gate_ctrl_clk, gate_pi_clk, gate_phy_clk, gate_dram_clk}, 4'b1111);
    recover();

    // R7 lp4 gating of srpd
    setcfg(0, 0, 0, 1, 0, 0); cyc(0, 0, 0);
    idle_n(1100);
    check("R7 no srpd without lp4", state_req, 6'b000001);
    setcfg(0, 0, 0, 1, 0, 1); cyc(0, 0, 0);
    idle_n(1024);
    check("R7 srpd with lp4", state_req, 6'b010000);
    recover();

    // R4 standby after srpd, R6 only deeper
    setcfg(0, 1, 0, 1, 1500, 1); cyc(0, 0, 0);
    idle_n(1024);
    check("R6 srpd wins over sr", state_req, 6'b010000);
    idle_n(475);
    check("R4 before standby", state_req, 6'b010000);
    idle_n(1);
    check("R4 standby at 1500", state_req, 6'b100000);
    recover();

    // R10 config frozen outside active
    setcfg(2, 1, 0, 0, 0, 0); cyc(0, 0, 0);
    idle_n(2);
    check("R10 pd entered", state_req, 6'b000010);
    setcfg(0, 0, 0, 0, 3, 0);
    idle_n(1022);
    check("R10 old sr threshold used", state_req, 6'b000100);
    recover();
    idle_n(2);
    check("R10 new config after wake", state_req, 6'b000001);
    idle_n(1);
    check("R10 new standby value", state_req, 6'b100000);
    recover();

    // constrained random episodes
    while ($time < 150000 * CLK_PERIOD) begin
      int len;
      setcfg($urandom_range(0, 40), $urandom_range(0, 2), $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 5000), $urandom_range(0, 1));
      cyc(0, 0, 0);
      len = $urandom_range(50, 4500);
      for (int i = 0; i < len; i++) begin
        int r = $urandom_range(0, 999);
        cyc(r >= 3, r == 0, wake_pend && ($urandom_range(0, 4) == 0));
      end
      recover();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule